// File: doc/BRIEF.md
# Deferred Write-Retire Column Unit

This block is the device-side column unit of a memory array that performs writes in two steps. A write command aimed at this device captures its bank and column into a single-entry write buffer. The data word is sampled a fixed number of cycles later. The entry is then committed to the bank's sense-amp storage in a later column slot, with an optional per-byte mask.

Every clock cycle is one column-packet slot. The commit is first attempted `T_RTR` slots after the write. It is skipped in any slot that carries no framed packet, and in any slot whose packet is a read to this device. After a skip, the unit keeps trying in every later slot until the commit succeeds. A read to this device therefore sees the old array contents until the commit has taken place. Reads are always served from the array, never from the buffer, and return their data `T_CAC` cycles after the command.

Top module: `wrbuf_colunit`

## Requirements
- R1: After reset `rd_valid` is 0, the buffer is empty and every array word reads back as 0.
- R2: Opcodes are 2'b00 no-op, 2'b01 write, 2'b10 read and 2'b11 treated as a no-op. A framed write whose `col_dev` equals `my_dev` captures `{col_bank, col_col}` into the buffer, and `wdata` is sampled at the clock edge `T_CWD` edges after the write's edge.
- R3: The first commit attempt falls on the slot `T_RTR` edges after the write. A slot with `col_frame` = 0 never commits.
- R4: A framed read to this device in a slot where a commit is due defers the commit, whatever bank and column it targets. Any number of such reads in a row keeps deferring it.
- R5: A framed read to another device, a write to any device or a no-op to any device in a due slot lets the commit take place.
- R6: In the committing slot, with `msk_valid` = 1, byte i (bits i*BYTE_W upward) of the stored word is written only when `msk_bits[i]` = 1. With `msk_valid` = 0, all bytes are written.
- R7: A read of the buffered bank and column issued before the commit returns the old word. A read issued after the commit returns the new word.
- R8: A framed read to this device sampled at edge k raises `rd_valid` with the array word after edge k+T_CAC-1, for that one cycle only. Reads to other devices, and reserved opcodes, raise no `rd_valid`.
- R9: A write to this device that arrives while an entry with captured data is still pending commits that entry in the same slot, then captures the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one column slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_dev | input | DEV_W | Identifier of this device |
| col_frame | input | 1 | Column packet present in this slot |
| col_op | input | 2 | Column opcode |
| col_dev | input | DEV_W | Target device of the packet |
| col_bank | input | BANK_W | Target bank |
| col_col | input | COL_W | Target column |
| msk_valid | input | 1 | Mask packet present in this slot |
| msk_bits | input | NBYTE | Per-byte write enables |
| wdata | input | NBYTE*BYTE_W | Write data word |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | NBYTE*BYTE_W | Read data word |

## Verification
The assertions assume that writes to this device are spaced more than `T_CWD` slots apart. A pending entry therefore always holds its data before a new write can flush it, and a data capture never falls in the same slot as a new write. The stimulus keeps to this rule. Every back-to-back write pair it sends is at least `T_CWD`+1 slots apart, while it still sends the second write before the first commit attempt is due. Deferral is driven with runs of unframed slots and same-device reads to varied banks before a releasing command.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;
   typedef enum logic [1:0] {
      OP_NOP = 2'b00,
      OP_WR  = 2'b01,
      OP_RD  = 2'b10,
      OP_RSV = 2'b11
   } col_op_e;
endpackage

// File: rtl/wrbuf_decode.sv
module wrbuf_decode
   import wrbuf_pkg::*;
#(
   parameter int DEV_W = 4
) (
   input  logic             frame,
   input  logic [1:0]       op,
   input  logic [DEV_W-1:0] dev,
   input  logic [DEV_W-1:0] my_dev,
   output logic             own_rd,
   output logic             own_wr
);
   logic hit;
   assign hit    = frame && (dev == my_dev);
   assign own_rd = hit && (op == OP_RD);
   assign own_wr = hit && (op == OP_WR);
endmodule

// File: rtl/wrbuf_retire.sv
module wrbuf_retire #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int NBYTE  = 2,
   parameter int T_CWD  = 2,
   parameter int T_RTR  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame,
   input  logic              own_rd,
   input  logic              own_wr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              msk_valid,
   input  logic [NBYTE-1:0]  msk_bits,
   output logic              retire_en,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [DATA_W-1:0] buf_data,
   output logic [NBYTE-1:0]  ret_mask,
   output logic              buf_valid,
   output logic              buf_dok
);
   localparam int CNT_W = $clog2(T_RTR) + 1;

   logic [T_CWD-1:0] cap_sr;
   logic             capture;
   logic [CNT_W-1:0] age_q;

   generate
      if (T_CWD == 1) begin : g_cap_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_sr <= '0;
            else        cap_sr <= own_wr;
         end
      end else begin : g_cap_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_sr <= '0;
            else        cap_sr <= {cap_sr[T_CWD-2:0], own_wr};
         end
      end
   endgenerate

   assign capture   = cap_sr[T_CWD-1];
   assign retire_en = buf_valid && buf_dok && frame && !own_rd &&
                      ((age_q == '0) || own_wr);
   assign ret_mask  = msk_valid ? msk_bits : {NBYTE{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_valid <= 1'b0;
         buf_dok   <= 1'b0;
         buf_addr  <= '0;
         buf_data  <= '0;
         age_q     <= '0;
      end else begin
         if (retire_en) buf_valid <= 1'b0;
         if (capture) begin
            buf_data <= wdata;
            buf_dok  <= 1'b1;
         end
         if (own_wr) begin
            buf_valid <= 1'b1;
            buf_dok   <= 1'b0;
            buf_addr  <= wr_addr;
            age_q     <= CNT_W'(T_RTR - 1);
         end else if (age_q != '0) begin
            age_q <= age_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/wrbuf_array.sv
module wrbuf_array #(
   parameter int ADDR_W = 8,
   parameter int NBYTE  = 2,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [NBYTE*BYTE_W-1:0] wdata,
   input  logic [NBYTE-1:0]        wmask,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [NBYTE*BYTE_W-1:0] rdata
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int DATA_W = NBYTE * BYTE_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] bitmask;
   logic [DATA_W-1:0] merged;

   generate
      for (genvar g = 0; g < NBYTE; g++) begin : g_byte
         assign bitmask[g*BYTE_W +: BYTE_W] = {BYTE_W{wmask[g]}};
      end
   endgenerate

   assign merged = (wdata & bitmask) | (mem[waddr] & ~bitmask);
   assign rdata  = mem[raddr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= merged;
      end
   end
endmodule

// File: rtl/wrbuf_rdpipe.sv
module wrbuf_rdpipe #(
   parameter int DATA_W = 16,
   parameter int T_CAC  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   logic              v_q [T_CAC];
   logic [DATA_W-1:0] d_q [T_CAC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < T_CAC; i++) begin
            v_q[i] <= 1'b0;
            d_q[i] <= '0;
         end
      end else begin
         v_q[0] <= in_valid;
         d_q[0] <= in_data;
         for (int i = 1; i < T_CAC; i++) begin
            v_q[i] <= v_q[i-1];
            d_q[i] <= d_q[i-1];
         end
      end
   end

   assign out_valid = v_q[T_CAC-1];
   assign out_data  = d_q[T_CAC-1];
endmodule

// File: rtl/wrbuf_colunit.sv
module wrbuf_colunit #(
   parameter int DEV_W  = 4,
   parameter int BANK_W = 3,
   parameter int COL_W  = 5,
   parameter int NBYTE  = 2,
   parameter int BYTE_W = 8,
   parameter int T_CWD  = 2,
   parameter int T_RTR  = 4,
   parameter int T_CAC  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [DEV_W-1:0]        my_dev,
   input  logic                    col_frame,
   input  logic [1:0]              col_op,
   input  logic [DEV_W-1:0]        col_dev,
   input  logic [BANK_W-1:0]       col_bank,
   input  logic [COL_W-1:0]        col_col,
   input  logic                    msk_valid,
   input  logic [NBYTE-1:0]        msk_bits,
   input  logic [NBYTE*BYTE_W-1:0] wdata,
   output logic                    rd_valid,
   output logic [NBYTE*BYTE_W-1:0] rd_data
);
   localparam int ADDR_W = BANK_W + COL_W;
   localparam int DATA_W = NBYTE * BYTE_W;

   generate
      if (T_CWD < 1)      begin : g_bad_cwd $error("T_CWD must be at least 1"); end
      if (T_RTR <= T_CWD) begin : g_bad_rtr $error("T_RTR must exceed T_CWD"); end
      if (T_CAC < 1)      begin : g_bad_cac $error("T_CAC must be at least 1"); end
      if (ADDR_W > 12)    begin : g_bad_adr $error("array too deep"); end
   endgenerate

   logic              own_rd, own_wr, retire_en, buf_valid, buf_dok;
   logic [ADDR_W-1:0] buf_addr, cmd_addr;
   logic [DATA_W-1:0] buf_data, arr_q;
   logic [NBYTE-1:0]  ret_mask;

   assign cmd_addr = {col_bank, col_col};

   wrbuf_decode #(.DEV_W(DEV_W)) u_dec (
      .frame(col_frame), .op(col_op), .dev(col_dev), .my_dev(my_dev),
      .own_rd(own_rd), .own_wr(own_wr)
   );

   wrbuf_retire #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTE(NBYTE),
      .T_CWD(T_CWD), .T_RTR(T_RTR)
   ) u_ret (
      .clk(clk), .rst_n(rst_n), .frame(col_frame), .own_rd(own_rd),
      .own_wr(own_wr), .wr_addr(cmd_addr), .wdata(wdata),
      .msk_valid(msk_valid), .msk_bits(msk_bits), .retire_en(retire_en),
      .buf_addr(buf_addr), .buf_data(buf_data), .ret_mask(ret_mask),
      .buf_valid(buf_valid), .buf_dok(buf_dok)
   );

   wrbuf_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .we(retire_en), .waddr(buf_addr),
      .wdata(buf_data), .wmask(ret_mask), .raddr(cmd_addr), .rdata(arr_q)
   );

   wrbuf_rdpipe #(.DATA_W(DATA_W), .T_CAC(T_CAC)) u_rdp (
      .clk(clk), .rst_n(rst_n), .in_valid(own_rd), .in_data(arr_q),
      .out_valid(rd_valid), .out_data(rd_data)
   );
endmodule

// File: rtl/wrbuf_colunit_chk.sv
module wrbuf_colunit_chk
   import wrbuf_pkg::*;
#(
   parameter int DEV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             col_frame,
   input logic [1:0]       col_op,
   input logic [DEV_W-1:0] col_dev,
   input logic [DEV_W-1:0] my_dev,
   input logic             own_wr,
   input logic             retire_en,
   input logic             buf_valid,
   input logic             buf_dok
);
   AST_RETIRE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
      retire_en |-> col_frame);  // R3
   AST_RETIRE_NOT_SELF_RD: assert property (@(posedge clk) disable iff (!rst_n)
      retire_en |-> !(col_op == OP_RD && col_dev == my_dev));  // R4
   AST_RETIRE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      retire_en |-> (buf_valid && buf_dok));  // R2
   AST_NEW_WR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
      (own_wr && buf_valid) |-> retire_en);  // R9
   AST_ENTRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && !retire_en && !own_wr) |=> buf_valid);  // R4
   AST_EMPTY_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_en && !own_wr) |=> !buf_valid);  // R3
endmodule

bind wrbuf_colunit wrbuf_colunit_chk #(.DEV_W(DEV_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .col_frame(col_frame), .col_op(col_op),
   .col_dev(col_dev), .my_dev(my_dev), .own_wr(own_wr),
   .retire_en(retire_en), .buf_valid(buf_valid), .buf_dok(buf_dok)
);

// File: tb/wrbuf_colunit_tb_top.sv
`timescale 1ns/1ps
module wrbuf_colunit_tb_top;
   localparam int DEV_W = 4, BANK_W = 3, COL_W = 5, NBYTE = 2, BYTE_W = 8;
   localparam int T_CWD = 2, T_RTR = 4, T_CAC = 3;
   localparam int DW = NBYTE * BYTE_W;
   localparam int ME = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DEV_W-1:0]  my_dev = DEV_W'(ME);
   logic              col_frame = 1'b0;
   logic [1:0]        col_op = 2'b00;
   logic [DEV_W-1:0]  col_dev = '0;
   logic [BANK_W-1:0] col_bank = '0;
   logic [COL_W-1:0]  col_col = '0;
   logic              msk_valid = 1'b0;
   logic [NBYTE-1:0]  msk_bits = '0;
   logic [DW-1:0]     wdata = '0;
   logic              rd_valid;
   logic [DW-1:0]     rd_data;

   always #10 clk = ~clk;  // 50 MHz

   wrbuf_colunit #(
      .DEV_W(DEV_W), .BANK_W(BANK_W), .COL_W(COL_W), .NBYTE(NBYTE),
      .BYTE_W(BYTE_W), .T_CWD(T_CWD), .T_RTR(T_RTR), .T_CAC(T_CAC)
   ) dut_i (.*);

   int    n_tests = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural reference model
   int            cyc = 0;
   logic [DW-1:0] m_mem [int];
   bit            exp_v [int];
   logic [DW-1:0] exp_d [int];
   bit            b_valid = 0, b_ok = 0;
   int            b_addr = 0, b_edge = 0;
   logic [DW-1:0] b_data = '0;

   function automatic logic [DW-1:0] peek(int a);
      return m_mem.exists(a) ? m_mem[a] : '0;
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit            s_rd, s_wr;
         int            a;
         logic [DW-1:0] w;
         cyc++;
         a    = {col_bank, col_col};
         s_rd = col_frame && col_op == 2'b10 && col_dev == my_dev;
         s_wr = col_frame && col_op == 2'b01 && col_dev == my_dev;
         if (s_rd) begin
            exp_v[cyc + T_CAC - 1] = 1;
            exp_d[cyc + T_CAC - 1] = peek(a);
         end
         if (b_valid && b_ok && col_frame && !s_rd &&
             ((cyc - b_edge) >= T_RTR || s_wr)) begin
            w = peek(b_addr);
            for (int i = 0; i < NBYTE; i++)
               if (!msk_valid || msk_bits[i])
                  w[i*BYTE_W +: BYTE_W] = b_data[i*BYTE_W +: BYTE_W];
            m_mem[b_addr] = w;
            b_valid = 0;
         end
         if (b_valid && !b_ok && cyc == b_edge + T_CWD) begin
            b_data = wdata;
            b_ok   = 1;
         end
         if (s_wr) begin
            b_valid = 1; b_ok = 0; b_addr = a; b_edge = cyc;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_tests++;
         if (rd_valid !== exp_v.exists(cyc)) begin
            n_fail++;
            $display("FAIL %s cycle %0d rd_valid act %0b exp %0b",
                     cur_req, cyc, rd_valid, exp_v.exists(cyc));
         end else if (exp_v.exists(cyc) && rd_data !== exp_d[cyc]) begin
            n_fail++;
            $display("FAIL %s cycle %0d rd_data act %h exp %h",
                     cur_req, cyc, rd_data, exp_d[cyc]);
         end
      end
   end

   // one slot: drive at negedge, hold for one cycle
   task automatic slot(input bit f, input logic [1:0] op, input int dev,
                       input int bank, input int col, input bit mv,
                       input int m, input int wd);
      col_frame = f;
      col_op    = op;
      col_dev   = DEV_W'(dev);
      col_bank  = BANK_W'(bank);
      col_col   = COL_W'(col);
      msk_valid = mv;
      msk_bits  = NBYTE'(m);
      wdata     = DW'(wd);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) slot(0, 2'b00, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, read back a few words
      cur_req = "R1";
      n_tests++;
      if (rd_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 rd_valid after reset act %0b exp 0", rd_valid);
      end
      slot(1, 2'b10, ME, 7, 31, 0, 0, 0);
      slot(1, 2'b10, ME, 0, 0, 0, 0, 0);
      idle(4);

      // R2 R3 R7: plain write, read before and after the commit
      cur_req = "R2/R3/R7";
      slot(1, 2'b01, ME, 1, 2, 0, 0, 0);
      slot(1, 2'b10, ME, 1, 2, 0, 0, 0);        // old data
      slot(1, 2'b00, ME, 0, 0, 0, 0, 'hA5C3);   // data edge
      slot(1, 2'b00, 3, 0, 0, 0, 0, 0);
      slot(1, 2'b00, ME, 0, 0, 0, 0, 0);        // commit slot
      slot(1, 2'b10, ME, 1, 2, 0, 0, 0);        // new data
      idle(5);

      // R3 R4 R5 R6: unframed skip, run of own reads, release by foreign read
      cur_req = "R4/R5/R6";
      slot(1, 2'b01, ME, 2, 7, 0, 0, 0);
      idle(1);
      slot(0, 2'b00, 0, 0, 0, 0, 0, 'h1234);
      idle(2);                                  // due but unframed
      for (int i = 0; i < 10; i++) slot(1, 2'b10, ME, i % 8, i, 1, 3, 0);
      slot(1, 2'b10, ME, 2, 7, 0, 0, 0);        // still old
      slot(1, 2'b10, 9, 2, 7, 1, 1, 0);         // release, low byte only
      slot(1, 2'b10, ME, 2, 7, 0, 0, 0);        // expect 0x0034
      idle(5);

      // R5 R6: release by write to another device, no mask
      cur_req = "R5/R6";
      slot(1, 2'b01, ME, 4, 0, 0, 0, 0);
      idle(1);
      slot(1, 2'b00, 1, 0, 0, 0, 0, 'hBEEF);
      idle(1);
      slot(1, 2'b01, 2, 4, 0, 0, 0, 0);
      slot(1, 2'b10, ME, 4, 0, 0, 0, 0);
      idle(5);

      // R9: second write flushes pending entry with high-byte mask
      cur_req = "R9";
      slot(1, 2'b01, ME, 5, 5, 0, 0, 0);
      idle(1);
      slot(1, 2'b00, 0, 0, 0, 0, 0, 'h1111);
      slot(1, 2'b01, ME, 6, 6, 1, 2, 0);        // flush old: 0x1100
      idle(1);
      slot(1, 2'b00, 0, 0, 0, 0, 0, 'h2222);
      idle(1);
      slot(1, 2'b00, 7, 0, 0, 0, 0, 0);         // commit second
      slot(1, 2'b10, ME, 5, 5, 0, 0, 0);
      slot(1, 2'b10, ME, 6, 6, 0, 0, 0);
      idle(5);

      // R8: foreign reads and reserved opcode give no data
      cur_req = "R8";
      slot(1, 2'b10, 9, 1, 2, 0, 0, 0);
      slot(1, 2'b11, ME, 1, 2, 0, 0, 0);
      slot(0, 2'b10, ME, 1, 2, 0, 0, 0);
      slot(1, 2'b10, ME, 1, 2, 0, 0, 0);
      slot(1, 2'b10, ME, 4, 0, 0, 0, 0);
      idle(6);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule